// File: doc/BRIEF.md
# Configuration Word Checksum Checker

This block validates a block of configuration words that some other agent reads out of a serial EEPROM. The words arrive one at a time, each qualified by a valid strobe. The stream has a fixed length set by a parameter. Every word except the last is added into a wide running sum. The last word is the checksum that was stored with the data, and the block compares it with that sum.

When the last word has been taken in, the block raises a done flag and a pass flag. Both stay where they are until software or a sequencer issues a new start pulse. The start pulse re-arms the block for another stream. A sum that is zero over its full width is treated as a failure. An erased or unpopulated device reads back as all zeros, so it can never be accepted.

The block does not fetch the words itself and does not repair bad data. It only judges the stream.

Top module: `cfg_sum_check`

## Requirements
- R1: After reset, done_o and pass_o are 0 and the block is armed to accept a fresh stream of NUM_WORDS words without needing a start pulse.
- R2: A start_i pulse clears the word count and the running sum, so words accepted before it do not affect the next verdict. A word presented with word_vld_i in the same cycle as start_i is not accepted.
- R3: The words at stream positions 0 to NUM_WORDS-2 are added into a sum at least 32 bits wide, and no carry out of bit 15 is lost.
- R4: pass_o is 1 only when bits [15:0] of the sum equal the final word (position NUM_WORDS-1) and the full sum is non-zero. Otherwise the verdict is fail (pass_o = 0 with done_o = 1).
- R5: If the full-width sum is zero, the verdict is fail even when the stored final word is 0.
- R6: A sum whose bits [15:0] are zero but whose upper bits are non-zero passes against a stored word of 0.
- R7: done_o and pass_o change on the clock edge that accepts the final word, so they are visible in the cycle after that word is presented. done_o is 0 while the final word is still being presented.
- R8: Once done_o is 1, done_o and pass_o hold their values until the next start_i.
- R9: Cycles with word_vld_i low are ignored whatever word_i holds. Valid words that arrive after the final word and before a new start_i are ignored and do not change the verdict.
- R10: In the cycle after start_i, done_o and pass_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that re-arms the checker |
| word_vld_i | input | 1 | word_i carries a stream word this cycle |
| word_i | input | WORD_W | Stream word, data or final stored checksum |
| done_o | output | 1 | Verdict available, held until next start |
| pass_o | output | 1 | Verdict is pass (meaningful with done_o) |

## Verification
Streams are tried with small values, with all-ones words that carry into the upper sum bits, with an all-zero stream against a zero checksum, and with a stream whose sum wraps exactly to a multiple of 65536. Together these separate a correct 16-bit compare from a full-width compare and from a missing zero test. Gapped valid strobes with garbage on word_i show that idle cycles add nothing. Extra words after the verdict, a start arriving together with a valid word, and a start in the middle of a stream show that the count and the sum are bounded and cleared at the right moments.

// File: rtl/cfg_sum_check_pkg.sv
package cfg_sum_check_pkg;
   // Width of a counter that must represent 0..n inclusive
   function automatic int unsigned cnt_bits(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w = w + 1;
      return w;
   endfunction

   // Minimum accumulator width that can hold n words of width ww without wrap
   function automatic int unsigned sum_bits(input int unsigned ww, input int unsigned n);
      return ww + cnt_bits(n);
   endfunction

   localparam int unsigned MIN_ACC_W = 32;
endpackage

// File: rtl/cfg_sum_check_cnt.sv
module cfg_sum_check_cnt
   import cfg_sum_check_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic word_vld_i,
   output logic accept_o,
   output logic last_o
);
   localparam int unsigned CNT_W = cnt_bits(NUM_WORDS);
   localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(NUM_WORDS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_WORDS - 1);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] pos_q;
   logic             armed;

   assign armed    = (pos_q != CNT_END);
   assign accept_o = word_vld_i & armed & ~start_i;
   assign last_o   = (pos_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (start_i) begin
         pos_q <= '0;
      end else if (accept_o) begin
         pos_q <= pos_q + CNT_ONE;
      end
   end
endmodule

// File: rtl/cfg_sum_check_acc.sv
module cfg_sum_check_acc #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ACC_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              add_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [ACC_W-1:0]  sum_o
);
   localparam int unsigned PAD_W = ACC_W - WORD_W;

   logic [ACC_W-1:0] word_ext;
   assign word_ext = {{PAD_W{1'b0}}, word_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_o <= '0;
      end else if (start_i) begin
         sum_o <= '0;
      end else if (add_i) begin
         sum_o <= sum_o + word_ext;
      end
   end
endmodule

// File: rtl/cfg_sum_check_verdict.sv
module cfg_sum_check_verdict #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ACC_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              judge_i,
   input  logic [ACC_W-1:0]  sum_i,
   input  logic [WORD_W-1:0] stored_i,
   output logic              done_o,
   output logic              pass_o
);
   logic sum_nonzero;
   logic low_match;

   assign sum_nonzero = |sum_i;
   assign low_match   = (sum_i[WORD_W-1:0] == stored_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         pass_o <= 1'b0;
      end else if (start_i) begin
         done_o <= 1'b0;
         pass_o <= 1'b0;
      end else if (judge_i) begin
         done_o <= 1'b1;
         pass_o <= sum_nonzero & low_match;
      end
   end
endmodule

// File: rtl/cfg_sum_check.sv
module cfg_sum_check
   import cfg_sum_check_pkg::*;
#(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned NUM_WORDS = 32,
   parameter int unsigned ACC_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              word_vld_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              done_o,
   output logic              pass_o
);
   localparam int unsigned NEED_W = sum_bits(WORD_W, NUM_WORDS);

   generate
      if (NUM_WORDS < 2) begin : g_bad_count
         $error("cfg_sum_check: NUM_WORDS must be at least 2");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("cfg_sum_check: WORD_W must be at least 1");
      end
      if (ACC_W < MIN_ACC_W) begin : g_bad_acc_min
         $error("cfg_sum_check: ACC_W below the 32-bit minimum");
      end
      if (ACC_W < NEED_W) begin : g_bad_acc_fit
         $error("cfg_sum_check: ACC_W too narrow for NUM_WORDS words");
      end
   endgenerate

   logic             accept;
   logic             last;
   logic             add_en;
   logic             judge_en;
   logic [ACC_W-1:0] sum;

   assign add_en   = accept & ~last;
   assign judge_en = accept &  last;

   cfg_sum_check_cnt #(
      .NUM_WORDS (NUM_WORDS)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .word_vld_i (word_vld_i),
      .accept_o   (accept),
      .last_o     (last)
   );

   cfg_sum_check_acc #(
      .WORD_W (WORD_W),
      .ACC_W  (ACC_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .add_i   (add_en),
      .word_i  (word_i),
      .sum_o   (sum)
   );

   cfg_sum_check_verdict #(
      .WORD_W (WORD_W),
      .ACC_W  (ACC_W)
   ) u_verdict (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .judge_i  (judge_en),
      .sum_i    (sum),
      .stored_i (word_i),
      .done_o   (done_o),
      .pass_o   (pass_o)
   );
endmodule

// File: rtl/cfg_sum_check_chk.sv
module cfg_sum_check_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic word_vld_i,
   input logic done_o,
   input logic pass_o
);
   // R4
   pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> done_o);

   // R8
   done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);

   // R8
   pass_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> $stable(pass_o));

   // R10
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && !pass_o));

   // R7
   done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(word_vld_i) && !$past(start_i)));
endmodule

bind cfg_sum_check cfg_sum_check_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .word_vld_i (word_vld_i),
   .done_o     (done_o),
   .pass_o     (pass_o)
);

// File: tb/cfg_sum_check_test.sv
module cfg_sum_check_test;
   localparam int CLK_P = 10;
   localparam int NW    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        word_vld_i = 1'b0;
   logic [15:0] word_i = 16'hDEAD;
   logic        done_o;
   logic        pass_o;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   cfg_sum_check #(.WORD_W(16), .NUM_WORDS(NW), .ACC_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_vld_i(word_vld_i),
      .word_i(word_i), .done_o(done_o), .pass_o(pass_o));

   // Behavioural reference: count, 64-bit sum, verdict
   int      m_cnt = 0;
   longint  m_sum = 0;
   bit      m_done = 0;
   bit      m_pass = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_sum = 0; m_done = 0; m_pass = 0;
      end else if (start_i) begin
         m_cnt = 0; m_sum = 0; m_done = 0; m_pass = 0;
      end else if (word_vld_i && m_cnt < NW) begin
         if (m_cnt < NW - 1) m_sum = m_sum + longint'(word_i);
         else begin
            m_done = 1;
            m_pass = (m_sum != 0) && ((m_sum & 64'hFFFF) == longint'(word_i));
         end
         m_cnt = m_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Every-cycle comparison against the reference (R7, R8)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(done_o == m_done, "R7/R8", "cycle done", int'(done_o), int'(m_done));
         check(pass_o == m_pass, "R7/R8", "cycle pass", int'(pass_o), int'(m_pass));
      end
   end

   task automatic put(input logic [15:0] w);
      word_vld_i = 1'b1; word_i = w;
      @(negedge clk);
      word_vld_i = 1'b0; word_i = 16'hDEAD;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   logic [15:0] fr [NW];

   function automatic bit exp_pass();
      longint s = 0;
      for (int i = 0; i < NW - 1; i++) s = s + longint'(fr[i]);
      return (s != 0) && ((s & 64'hFFFF) == longint'(fr[NW-1]));
   endfunction

   // Sends a frame; gap inserts idle cycles between words; checks R7 timing
   task automatic send_frame(input int gap, input string req);
      bit e;
      e = exp_pass();
      for (int i = 0; i < NW - 1; i++) begin
         put(fr[i]);
         idle(gap);
      end
      check(done_o == 1'b0, "R7", "done early", int'(done_o), 0);
      put(fr[NW-1]);
      check(done_o == 1'b1, req, "done", int'(done_o), 1);
      check(pass_o == e, req, "pass", int'(pass_o), int'(e));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      check(done_o == 1'b0, "R1", "reset done", int'(done_o), 0);
      check(pass_o == 1'b0, "R1", "reset pass", int'(pass_o), 0);

      // R1, R3, R4, R9: armed after reset, gapped stream, correct checksum
      for (int i = 0; i < NW - 1; i++) fr[i] = 16'(16'h0101 * (i + 1));
      fr[NW-1] = 16'h1C1C;
      send_frame(2, "R4");
      check(pass_o == 1'b1, "R9", "gaps ignored", int'(pass_o), 1);

      // R9: extra words after final one do not change verdict
      put(16'h0000); put(16'h1234); put(16'hFFFF);
      check(done_o == 1'b1 && pass_o == 1'b1, "R9", "extra words",
            int'({done_o, pass_o}), 3);
      idle(4);
      check(pass_o == 1'b1, "R8", "held", int'(pass_o), 1);

      // R10: start clears verdict
      pulse_start();
      check(done_o == 1'b0 && pass_o == 1'b0, "R10", "cleared",
            int'({done_o, pass_o}), 0);

      // R4: wrong checksum
      fr[NW-1] = 16'h1C1D;
      send_frame(0, "R4");
      pulse_start();

      // R3: carries beyond 16 bits, compare uses low bits
      for (int i = 0; i < NW - 1; i++) fr[i] = 16'hFFFF;
      fr[NW-1] = 16'hFFF9;
      send_frame(1, "R3");
      pulse_start();

      // R5: all zero stream against zero checksum fails
      for (int i = 0; i < NW; i++) fr[i] = 16'h0000;
      send_frame(0, "R5");
      check(pass_o == 1'b0, "R5", "zero sum", int'(pass_o), 0);
      pulse_start();

      // R6: sum wraps to 0x10000, stored 0 passes
      for (int i = 0; i < NW; i++) fr[i] = 16'h0000;
      fr[0] = 16'h8000; fr[3] = 16'h8000;
      send_frame(0, "R6");
      check(pass_o == 1'b1, "R6", "wrapped sum", int'(pass_o), 1);

      // R2: start together with a valid word; that word is not accepted
      start_i = 1'b1; word_vld_i = 1'b1; word_i = 16'h4444;
      @(negedge clk);
      start_i = 1'b0; word_vld_i = 1'b0;
      for (int i = 0; i < NW - 1; i++) fr[i] = 16'(i + 1);
      fr[NW-1] = 16'h001C;
      send_frame(0, "R2");
      pulse_start();

      // R2: start mid-stream discards partial sum
      put(16'h7777); put(16'h0F0F); put(16'h0001);
      pulse_start();
      check(done_o == 1'b0, "R2", "mid restart", int'(done_o), 0);
      for (int i = 0; i < NW - 1; i++) fr[i] = 16'h0010;
      fr[NW-1] = 16'h0070;
      send_frame(0, "R2");

      idle(2);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule